// File: doc/BRIEF.md
# Contention Parameter Normaliser

This block turns a requested set of channel-access settings for one transmit queue into legal values that the arbitration logic can use: the interframe spacing count, the minimum and maximum contention windows, and the short and long retry limits. Each field is clamped to its legal ceiling. A "use default" flag or a zero retry value substitutes a parameterised default. The two contention windows are rounded up to the nearest value of the form 2^n − 1.

A request is launched with a one-cycle `start` while the block is idle. The window rounding is iterative, one shift step per clock, and runs for both windows in parallel. When both windows are settled, all five outputs update together and `done` pulses for one cycle. When the default minimum window is requested, the `legacy_chan` flag at launch picks between two defaults: one for legacy spread-spectrum channels and one for all others.

Top module: `cw_param_norm`

## Requirements
- R1: After reset, every result output is zero and both `busy` and `done` are low.
- R2: `start` is accepted only while `busy` is low, and `busy` is high in the cycle after acceptance. A `start` raised while busy is ignored: the next results belong to the accepted request.
- R3: The spacing output is AIFS_DEF (2) when `aifs_use_dflt` is set. Otherwise it is the request clamped to at most 255.
- R4: A window request is clamped to at most 1024. The result is then the smallest value 2^n − 1 (n ≥ 1) that is not below the clamped request, so a request of 0 or 1 yields 1 and a request of 1024 yields 2047.
- R5: With `cwmin_use_dflt` set, the minimum window is the rounded CWMIN_LEG_DEF (31) when `legacy_chan` is high at launch, and the rounded CWMIN_DEF (15) otherwise.
- R6: With `cwmax_use_dflt` set, the maximum window is CWMAX_DEF (1023) as given, without rounding.
- R7: A short or long retry request of zero yields RETRY_DEF (10). A nonzero request is clamped to at most 15. The two limits are handled independently.
- R8: `done` is a one-cycle pulse, `busy` is low while it is high, and it rises S+1 cycles after the accepting edge. S is the larger shift count of the two windows; a defaulted maximum window needs zero shifts.
- R9: Result outputs change only on the edge that raises `done`, and hold their values between pulses.
- R10: A `start` presented in the cycle where `done` is high is accepted, so requests can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a normalisation (taken when idle) |
| legacy_chan | input | 1 | Channel is legacy spread-spectrum; picks the minimum-window default |
| aifs_req | input | REQ_W | Requested spacing count |
| aifs_use_dflt | input | 1 | Use the default spacing count |
| cwmin_req | input | REQ_W | Requested minimum window |
| cwmin_use_dflt | input | 1 | Use the channel-dependent default minimum window |
| cwmax_req | input | REQ_W | Requested maximum window |
| cwmax_use_dflt | input | 1 | Use the default maximum window |
| shretry_req | input | REQ_W | Requested short retry limit, 0 = default |
| lgretry_req | input | REQ_W | Requested long retry limit, 0 = default |
| busy | output | 1 | Normalisation in progress |
| done | output | 1 | One-cycle completion pulse |
| aifs_o | output | AIFS_W | Legal spacing count |
| cwmin_o | output | CW_W | Legal minimum window |
| cwmax_o | output | CW_W | Legal maximum window |
| shretry_o | output | RETRY_W | Legal short retry limit |
| lgretry_o | output | RETRY_W | Legal long retry limit |

## Verification
Completion of one request and acceptance of the next can fall in the same cycle, when `start` is presented while `done` is high. Stimulus from a fixed-seed random stream launches half of the requests in exactly that cycle and the rest after an idle gap. A spurious `start` is also injected during some runs. In every case the bench checks that the results of the finished request still hold in the cycle after the new acceptance. It then checks that the new request completes after the latency computed from its own shift counts, with values computed by bench functions.

// File: rtl/cpn_pkg.sv
package cpn_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } cpn_state_t;

  localparam int NUM_WIN = 2;
  localparam int WIN_MIN = 0;
  localparam int WIN_MAX = 1;
endpackage

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 8,
  parameter int MAX   = 255
) (
  input  logic [IN_W-1:0]  in_val,
  output logic [OUT_W-1:0] out_val
);
  localparam logic [IN_W-1:0]  MAX_IN  = IN_W'(MAX);
  localparam logic [OUT_W-1:0] MAX_OUT = OUT_W'(MAX);

  assign out_val = (in_val > MAX_IN) ? MAX_OUT : OUT_W'(in_val);
endmodule

// File: rtl/cw_round_step.sv
module cw_round_step #(
  parameter int CW_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [CW_W-1:0] target,
  output logic [CW_W-1:0] value,
  output logic            fin
);
  logic [CW_W-1:0] tgt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= CW_W'(1);
      tgt_q <= '0;
    end else if (load) begin
      value <= CW_W'(1);
      tgt_q <= target;
    end else if (value < tgt_q) begin
      value <= {value[CW_W-2:0], 1'b1};
    end
  end

  assign fin = (value >= tgt_q);
endmodule

// File: rtl/cw_param_norm.sv
module cw_param_norm
  import cpn_pkg::*;
#(
  parameter int REQ_W         = 16,
  parameter int AIFS_MAX      = 255,
  parameter int CW_LIMIT      = 1024,
  parameter int RETRY_MAX     = 15,
  parameter int AIFS_DEF      = 2,
  parameter int CWMIN_DEF     = 15,
  parameter int CWMIN_LEG_DEF = 31,
  parameter int CWMAX_DEF     = 1023,
  parameter int RETRY_DEF     = 10,
  localparam int AIFS_W  = $clog2(AIFS_MAX + 1),
  localparam int CW_W    = $clog2(CW_LIMIT) + 1,
  localparam int RETRY_W = $clog2(RETRY_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               legacy_chan,
  input  logic [REQ_W-1:0]   aifs_req,
  input  logic               aifs_use_dflt,
  input  logic [REQ_W-1:0]   cwmin_req,
  input  logic               cwmin_use_dflt,
  input  logic [REQ_W-1:0]   cwmax_req,
  input  logic               cwmax_use_dflt,
  input  logic [REQ_W-1:0]   shretry_req,
  input  logic [REQ_W-1:0]   lgretry_req,
  output logic               busy,
  output logic               done,
  output logic [AIFS_W-1:0]  aifs_o,
  output logic [CW_W-1:0]    cwmin_o,
  output logic [CW_W-1:0]    cwmax_o,
  output logic [RETRY_W-1:0] shretry_o,
  output logic [RETRY_W-1:0] lgretry_o
);
  localparam logic [AIFS_W-1:0]  AIFS_D    = AIFS_W'(AIFS_DEF);
  localparam logic [CW_W-1:0]    CWMIN_D   = CW_W'(CWMIN_DEF);
  localparam logic [CW_W-1:0]    CWMIN_L_D = CW_W'(CWMIN_LEG_DEF);
  localparam logic [CW_W-1:0]    CWMAX_D   = CW_W'(CWMAX_DEF);
  localparam logic [RETRY_W-1:0] RETRY_D   = RETRY_W'(RETRY_DEF);

  cpn_state_t state_q;
  logic       accept;

  logic [AIFS_W-1:0]  aifs_cl;
  logic [RETRY_W-1:0] sh_cl, lg_cl;
  logic [CW_W-1:0]    cwmin_cl, cwmax_cl;

  logic [CW_W-1:0]    win_tgt [NUM_WIN];
  logic [CW_W-1:0]    win_val [NUM_WIN];
  logic [NUM_WIN-1:0] win_fin;

  logic [AIFS_W-1:0]  aifs_s;
  logic [RETRY_W-1:0] sh_s, lg_s;
  logic               cwmax_dflt_s;

  assign accept = start && (state_q == ST_IDLE);

  sat_clamp #(.IN_W(REQ_W), .OUT_W(AIFS_W), .MAX(AIFS_MAX)) u_clamp_aifs (
    .in_val(aifs_req), .out_val(aifs_cl));
  sat_clamp #(.IN_W(REQ_W), .OUT_W(RETRY_W), .MAX(RETRY_MAX)) u_clamp_sh (
    .in_val(shretry_req), .out_val(sh_cl));
  sat_clamp #(.IN_W(REQ_W), .OUT_W(RETRY_W), .MAX(RETRY_MAX)) u_clamp_lg (
    .in_val(lgretry_req), .out_val(lg_cl));
  sat_clamp #(.IN_W(REQ_W), .OUT_W(CW_W), .MAX(CW_LIMIT)) u_clamp_cwmin (
    .in_val(cwmin_req), .out_val(cwmin_cl));
  sat_clamp #(.IN_W(REQ_W), .OUT_W(CW_W), .MAX(CW_LIMIT)) u_clamp_cwmax (
    .in_val(cwmax_req), .out_val(cwmax_cl));

  // Window targets: a defaulted maximum window needs no rounding, so it
  // finishes at once and its result is taken from the parameter.
  always_comb begin
    win_tgt[WIN_MIN] = cwmin_use_dflt ? (legacy_chan ? CWMIN_L_D : CWMIN_D)
                                      : cwmin_cl;
    win_tgt[WIN_MAX] = cwmax_use_dflt ? '0 : cwmax_cl;
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    cw_round_step #(.CW_W(CW_W)) u_round (
      .clk   (clk),
      .rst   (rst),
      .load  (accept),
      .target(win_tgt[g]),
      .value (win_val[g]),
      .fin   (win_fin[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aifs_s       <= '0;
      sh_s         <= '0;
      lg_s         <= '0;
      cwmax_dflt_s <= 1'b0;
    end else if (accept) begin
      aifs_s       <= aifs_use_dflt ? AIFS_D : aifs_cl;
      sh_s         <= (shretry_req == '0) ? RETRY_D : sh_cl;
      lg_s         <= (lgretry_req == '0) ? RETRY_D : lg_cl;
      cwmax_dflt_s <= cwmax_use_dflt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      aifs_o    <= '0;
      cwmin_o   <= '0;
      cwmax_o   <= '0;
      shretry_o <= '0;
      lgretry_o <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_RUN;
            busy    <= 1'b1;
          end
        end
        ST_RUN: begin
          if (&win_fin) begin
            state_q   <= ST_IDLE;
            busy      <= 1'b0;
            done      <= 1'b1;
            aifs_o    <= aifs_s;
            cwmin_o   <= win_val[WIN_MIN];
            cwmax_o   <= cwmax_dflt_s ? CWMAX_D : win_val[WIN_MAX];
            shretry_o <= sh_s;
            lgretry_o <= lg_s;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cw_param_norm_chk.sv
module cw_param_norm_chk #(
  parameter int AIFS_W  = 8,
  parameter int CW_W    = 11,
  parameter int RETRY_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [AIFS_W-1:0]  aifs_o,
  input logic [CW_W-1:0]    cwmin_o,
  input logic [CW_W-1:0]    cwmax_o,
  input logic [RETRY_W-1:0] shretry_o,
  input logic [RETRY_W-1:0] lgretry_o
);
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R8

  AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(aifs_o) && $stable(cwmin_o) && $stable(cwmax_o) &&
               $stable(shretry_o) && $stable(lgretry_o))); // R9

  AST_CWMIN_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    done |-> ((cwmin_o != '0) && ((cwmin_o & (cwmin_o + 1'b1)) == '0))); // R4

  AST_RETRY_NONZERO: assert property (@(posedge clk) disable iff (rst)
    done |-> ((shretry_o != '0) && (lgretry_o != '0))); // R7
endmodule

bind cw_param_norm cw_param_norm_chk #(
  .AIFS_W (AIFS_W),
  .CW_W   (CW_W),
  .RETRY_W(RETRY_W)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .aifs_o   (aifs_o),
  .cwmin_o  (cwmin_o),
  .cwmax_o  (cwmax_o),
  .shretry_o(shretry_o),
  .lgretry_o(lgretry_o)
);

// File: tb/test_cw_param_norm.sv
module test_cw_param_norm;
  localparam int REQ_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic             legacy_chan = 1'b0;
  logic [REQ_W-1:0] aifs_req = '0, cwmin_req = '0, cwmax_req = '0;
  logic [REQ_W-1:0] shretry_req = '0, lgretry_req = '0;
  logic             aifs_use_dflt = 1'b0, cwmin_use_dflt = 1'b0, cwmax_use_dflt = 1'b0;
  logic             busy, done;
  logic [7:0]       aifs_o;
  logic [10:0]      cwmin_o, cwmax_o;
  logic [3:0]       shretry_o, lgretry_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit finished = 1'b0;

  // expected results of the last completed request
  int e_aifs = 0, e_cwmin = 0, e_cwmax = 0, e_sh = 0, e_lg = 0;

  cw_param_norm i_cw_param_norm (
    .clk(clk), .rst(rst), .start(start), .legacy_chan(legacy_chan),
    .aifs_req(aifs_req), .aifs_use_dflt(aifs_use_dflt),
    .cwmin_req(cwmin_req), .cwmin_use_dflt(cwmin_use_dflt),
    .cwmax_req(cwmax_req), .cwmax_use_dflt(cwmax_use_dflt),
    .shretry_req(shretry_req), .lgretry_req(lgretry_req),
    .busy(busy), .done(done), .aifs_o(aifs_o), .cwmin_o(cwmin_o),
    .cwmax_o(cwmax_o), .shretry_o(shretry_o), .lgretry_o(lgretry_o));

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd_cw(input int req);
    int t = (req > 1024) ? 1024 : req;
    int w = 1;
    while (w < t) w = (w << 1) | 1;
    return w;
  endfunction

  function automatic int steps_cw(input int req);
    int t = (req > 1024) ? 1024 : req;
    int w = 1;
    int n = 0;
    while (w < t) begin w = (w << 1) | 1; n++; end
    return n;
  endfunction

  function automatic int exp_retry(input int req);
    if (req == 0) return 10;
    return (req > 15) ? 15 : req;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // Called at a negedge with the block idle or showing done.
  task automatic run_case(input int a, input bit ad, input int cmn, input bit cmnd,
                          input int cmx, input bit cmxd, input int sh, input int lg,
                          input bit leg, input bit poke);
    int xa, xmn, xmx, xsh, xlg, s_mn, s_mx, lat, cnt;
    xa   = ad ? 2 : ((a > 255) ? 255 : a);
    xmn  = cmnd ? rnd_cw(leg ? 31 : 15) : rnd_cw(cmn);
    s_mn = cmnd ? steps_cw(leg ? 31 : 15) : steps_cw(cmn);
    xmx  = cmxd ? 1023 : rnd_cw(cmx);
    s_mx = cmxd ? 0 : steps_cw(cmx);
    xsh  = exp_retry(sh);
    xlg  = exp_retry(lg);
    lat  = ((s_mn > s_mx) ? s_mn : s_mx) + 1;

    aifs_req = REQ_W'(a); aifs_use_dflt = ad;
    cwmin_req = REQ_W'(cmn); cwmin_use_dflt = cmnd;
    cwmax_req = REQ_W'(cmx); cwmax_use_dflt = cmxd;
    shretry_req = REQ_W'(sh); lgretry_req = REQ_W'(lg);
    legacy_chan = leg;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after accept (R10 when launched on done)", int'(busy), 1);
    chk("R9 aifs held", int'(aifs_o), e_aifs);
    chk("R9 cwmin held", int'(cwmin_o), e_cwmin);
    if (poke) begin
      // R2: a start while busy with different requests must be ignored
      aifs_req = 16'hFFFF; aifs_use_dflt = 1'b0;
      cwmin_req = 16'd0; cwmin_use_dflt = 1'b0;
      cwmax_req = 16'd3; cwmax_use_dflt = 1'b0;
      shretry_req = 16'd0; lgretry_req = 16'd1; legacy_chan = ~leg;
      start = 1'b1;
    end
    cnt = 0;
    while (!done && cnt < 40) begin
      @(negedge clk);
      start = 1'b0;
      cnt++;
    end
    chk("R8 latency to done", cnt, lat);
    chk("R8 busy low with done", int'(busy), 0);
    chk("R3 aifs", int'(aifs_o), xa);
    chk(cmnd ? "R5 cwmin default" : "R4 cwmin rounding", int'(cwmin_o), xmn);
    chk(cmxd ? "R6 cwmax default" : "R4 cwmax rounding", int'(cwmax_o), xmx);
    chk("R7 short retry", int'(shretry_o), xsh);
    chk("R7 long retry", int'(lgretry_o), xlg);
    e_aifs = xa; e_cwmin = xmn; e_cwmax = xmx; e_sh = xsh; e_lg = xlg;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 aifs", int'(aifs_o), 0);
    chk("R1 cwmin", int'(cwmin_o), 0);
    chk("R1 cwmax", int'(cwmax_o), 0);
    chk("R1 retries", int'(shretry_o) + int'(lgretry_o), 0);

    // directed corners
    run_case(300, 0, 0, 0, 1024, 0, 0, 16, 0, 0);      // R3 clamp, R4 0->1 and 1024->2047, R7
    run_case(255, 0, 1, 0, 2000, 0, 15, 0, 0, 1);      // R4 limit, R2 poke
    run_case(7, 1, 0, 1, 5, 1, 3, 100, 1, 0);          // R5 legacy, R6, R3 default
    run_case(0, 0, 16, 1, 512, 0, 1, 9, 0, 0);         // R5 standard; back to back (R10)
    run_case(1, 0, 16, 0, 17, 0, 65535, 0, 1, 1);      // R4 power of two boundaries
    @(negedge clk);
    run_case(65535, 0, 1023, 0, 1025, 0, 14, 15, 0, 0);

    for (int i = 0; i < 200; i++) begin
      int a, cmn, cmx, sh, lg;
      bit ad, cmnd, cmxd, leg, poke;
      a    = ($urandom % 2) ? int'($urandom % 300) : int'($urandom % 65536);
      cmn  = ($urandom % 2) ? int'($urandom % 1100) : int'($urandom % 65536);
      cmx  = ($urandom % 2) ? int'($urandom % 1100) : int'($urandom % 65536);
      sh   = ($urandom % 3 == 0) ? 0 : int'($urandom % 40);
      lg   = ($urandom % 3 == 0) ? 0 : int'($urandom % 40);
      ad   = ($urandom % 4 == 0);
      cmnd = ($urandom % 4 == 0);
      cmxd = ($urandom % 4 == 0);
      leg  = $urandom % 2;
      poke = ($urandom % 3 == 0);
      if (i % 2 == 1) repeat (1 + $urandom % 3) @(negedge clk);
      run_case(a, ad, cmn, cmnd, cmx, cmxd, sh, lg, leg, poke);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule